// File: doc/BRIEF.md
# Masked Flash Status-Register Updater

This block runs as an SPI master that changes chosen bits of a serial flash's two 8-bit status registers. The register pair is handled as one 16-bit word: the first register is the low byte and the second is the high byte. A request gives a 16-bit mask, a 16-bit value and a persistence flag. It can also ask for a lock mode. The block reads both registers. If the masked bits already hold the requested value, it finishes without writing.

Otherwise the block merges the requested bits into the word it read. It sends the write-enable opcode that matches the persistence flag, then writes both registers in one frame. It then waits: for a persistent write it polls the busy flag, and for a volatile write it waits a fixed delay. Last, it reads both registers back. A masked mismatch means the register is locked. The SPI shifter is part of the block. It runs in mode 0, with the clock idle low, data sampled on the rising edge and data changed on the falling edge. All bytes go out MSB first.

Top module: `sreg_update_seq`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next cycle. The block then sends a 0x05 read frame followed by a 0x35 read frame. Each frame is one opcode byte and one data byte, and the two data bytes form the current word {second, first}.
- R2: When (value & mask) equals (current & mask), the block ends after the two reads. No further frame is sent, and `wrote`, `err_lock` and `err_timeout` stay 0.
- R3: Before writing, the block sends a one-byte enable frame. It is 0x06 when `persist` is 1 and 0x50 when `persist` is 0.
- R4: The write frame is 0x01, then the low byte, then the high byte of (current & ~mask) | (value & mask). `wrote` is 1 when the operation ends.
- R5: After a persistent write the block sends 0x05 poll frames until read bit 0 (busy) is 0. If POLL_MAX polls all read busy, it ends with `err_timeout` = 1 and does no read-back.
- R6: After a volatile write, chip select stays high for at least ceil(CLK_HZ/1e6) clock cycles (1 us) before the next frame.
- R7: After the wait, the block reads 0x05 and then 0x35 again. `err_lock` is 1 exactly when the masked read-back differs from the masked requested value.
- R8: With `lock_en` = 1, bit 0 of `lock_mode` sets word bit 7 and bit 1 sets word bit 8, and both bits are added to the mask. The codes are 0 none, 1 pin, 2 until power cycle and 3 permanent.
- R9: `spi_sck` is low whenever `spi_cs_n` is high. `busy` falls only in the cycle where `done` is asserted.
- R10: After reset, `spi_cs_n` = 1, `spi_sck` = 0 and `busy` = `done` = 0. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an update (taken while idle) |
| mask | input | 16 | Bits to change in {reg2, reg1} |
| value | input | 16 | Requested bit values |
| persist | input | 1 | 1 = non-volatile write, 0 = volatile |
| lock_en | input | 1 | Apply the lock-mode field |
| lock_mode | input | 2 | Lock code: 0 none, 1 pin, 2 power cycle, 3 permanent |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle end pulse |
| wrote | output | 1 | A write frame was sent |
| err_lock | output | 1 | Read-back mismatch |
| err_timeout | output | 1 | Busy never cleared |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |

## Verification
A behavioural flash model in the bench answers reads, takes the enables and writes, can freeze chosen bits and can hold busy for a set number of polls. Requests whose masked bits already match test the skip path against a real update. Volatile and persistent requests show which enable opcode is sent and which wait follows. Busy counts of POLL_MAX-1 and POLL_MAX test the last successful poll against a timeout. Frozen bits test the locked-register verdict, and lock-mode requests with an empty caller mask test the folding of the mode bits into bits 7 and 8.

// File: rtl/sreg_update_seq.sv
module sreg_update_seq #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int SCK_HALF = 2,
  parameter int POLL_MAX = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] mask,
  input  logic [15:0] value,
  input  logic        persist,
  input  logic        lock_en,
  input  logic [1:0]  lock_mode,
  output logic        busy,
  output logic        done,
  output logic        wrote,
  output logic        err_lock,
  output logic        err_timeout,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int US_CYC = (CLK_HZ + 999_999) / 1_000_000;
  localparam int WW = $clog2(US_CYC + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int DW = $clog2(SCK_HALF + 1);
  localparam logic [7:0] OP_RD_LO = 8'h05, OP_RD_HI = 8'h35, OP_WEN = 8'h06,
                         OP_VWEN = 8'h50, OP_WRS = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE, S_RD1, S_RD2, S_WEN, S_WRS, S_POLL, S_WAIT, S_VR1, S_VR2
  } st_t;

  st_t st;
  logic [15:0] m_l, v_l, cur, nxt_word, lk_m, lk_v;
  logic        pers_l, kick, active, fdone, match;
  logic [23:0] tx, frame;
  logic [7:0]  rx;
  logic [4:0]  bits, flen;
  logic [DW-1:0] dcnt;
  logic [WW-1:0] wcnt;
  logic [PW-1:0] polls;

  assign lk_m     = lock_en ? 16'h0180 : 16'h0000;
  assign lk_v     = lock_en ? {7'b0, lock_mode[1], lock_mode[0], 7'b0} : 16'h0000;
  assign nxt_word = (cur & ~m_l) | (v_l & m_l);
  assign match    = ({rx, cur[7:0]} & m_l) == (v_l & m_l);
  assign busy     = (st != S_IDLE);
  assign spi_mosi = tx[23];

  always_comb begin
    frame = {OP_RD_LO, 16'h0000};
    flen  = 5'd16;
    case (st)
      S_RD2, S_VR2: frame = {OP_RD_HI, 16'h0000};
      S_WEN: begin
        frame = {pers_l ? OP_WEN : OP_VWEN, 16'h0000};
        flen  = 5'd8;
      end
      S_WRS: begin
        frame = {OP_WRS, nxt_word[7:0], nxt_word[15:8]};
        flen  = 5'd24;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; m_l <= '0; v_l <= '0; cur <= '0; pers_l <= 1'b0;
      kick <= 1'b0; done <= 1'b0; wrote <= 1'b0;
      err_lock <= 1'b0; err_timeout <= 1'b0; wcnt <= '0; polls <= '0;
    end else begin
      kick <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m_l <= mask | lk_m;
          v_l <= (value & ~lk_m) | lk_v;
          pers_l <= persist;
          wrote <= 1'b0; err_lock <= 1'b0; err_timeout <= 1'b0;
          st <= S_RD1; kick <= 1'b1;
        end
        S_RD1: if (fdone) begin cur[7:0] <= rx; st <= S_RD2; kick <= 1'b1; end
        S_RD2: if (fdone) begin
          cur[15:8] <= rx;
          if (match) begin st <= S_IDLE; done <= 1'b1; end
          else begin st <= S_WEN; kick <= 1'b1; end
        end
        S_WEN: if (fdone) begin st <= S_WRS; kick <= 1'b1; end
        S_WRS: if (fdone) begin
          wrote <= 1'b1; polls <= '0; wcnt <= '0;
          if (pers_l) begin st <= S_POLL; kick <= 1'b1; end
          else st <= S_WAIT;
        end
        S_POLL: if (fdone) begin
          if (!rx[0]) begin st <= S_VR1; kick <= 1'b1; end
          else if (polls == PW'(POLL_MAX - 1)) begin
            st <= S_IDLE; done <= 1'b1; err_timeout <= 1'b1;
          end else begin polls <= polls + 1'b1; kick <= 1'b1; end
        end
        S_WAIT: if (wcnt == WW'(US_CYC - 1)) begin st <= S_VR1; kick <= 1'b1; end
                else wcnt <= wcnt + 1'b1;
        S_VR1: if (fdone) begin cur[7:0] <= rx; st <= S_VR2; kick <= 1'b1; end
        S_VR2: if (fdone) begin st <= S_IDLE; done <= 1'b1; err_lock <= !match; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; spi_cs_n <= 1'b1; spi_sck <= 1'b0; dcnt <= '0;
      tx <= '0; rx <= '0; bits <= '0; fdone <= 1'b0;
    end else begin
      fdone <= 1'b0;
      if (kick) begin
        active <= 1'b1; spi_cs_n <= 1'b0; spi_sck <= 1'b0;
        dcnt <= '0; tx <= frame; bits <= flen;
      end else if (active) begin
        if (dcnt == DW'(SCK_HALF - 1)) begin
          dcnt <= '0;
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rx <= {rx[6:0], spi_miso};
          end else begin
            spi_sck <= 1'b0;
            tx <= {tx[22:0], 1'b0};
            bits <= bits - 5'd1;
            if (bits == 5'd1) begin
              active <= 1'b0; spi_cs_n <= 1'b1; fdone <= 1'b1;
            end
          end
        end else dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

module sreg_update_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err_lock,
  input logic err_timeout,
  input logic spi_sck,
  input logic spi_cs_n
);
  // R9
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_lock && err_timeout));
endmodule

bind sreg_update_seq sreg_update_seq_chk u_chk (.*);

// File: tb/sreg_update_seq_tb.sv
module sreg_update_seq_tb;
  localparam int PM = 8;
  localparam int US = 125;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, persist = 1'b0, lock_en = 1'b0;
  logic [1:0]  lock_mode = 2'd0;
  logic [15:0] mask = '0, value = '0;
  logic busy, done, wrote, err_lock, err_timeout, spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sreg_update_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .value(value),
    .persist(persist), .lock_en(lock_en), .lock_mode(lock_mode),
    .busy(busy), .done(done), .wrote(wrote), .err_lock(err_lock),
    .err_timeout(err_timeout), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash model
  logic [15:0] fl_reg = 16'h1234, frozen = '0;
  bit fl_wel = 0, fl_vwel = 0;
  int busy_left = 0, busy_cfg = 0, bitcnt = 0, wr_end = -1, gap = -1;
  logic [7:0] sh = '0, outb = '0, wr_lo = '0, wr_hi = '0;
  logic [7:0] fbytes[$];
  logic [7:0] ops[$];

  always @(negedge spi_cs_n) begin
    bitcnt = 0;
    fbytes.delete();
    if (wr_end >= 0 && gap < 0) gap = cyc - wr_end;
  end

  always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
    sh = {sh[6:0], spi_mosi};
    bitcnt++;
    if (bitcnt % 8 == 0) begin
      fbytes.push_back(sh);
      if (bitcnt == 8)
        outb = (sh == 8'h05) ? {fl_reg[7:2], fl_wel, (busy_left > 0)} :
               (sh == 8'h35) ? fl_reg[15:8] : 8'h00;
    end
  end

  always @(negedge spi_sck) if (spi_cs_n === 1'b0 && bitcnt >= 8)
    spi_miso = outb[7 - ((bitcnt - 8) % 8)];

  always @(posedge spi_cs_n) if (fbytes.size() > 0) begin
    ops.push_back(fbytes[0]);
    case (fbytes[0])
      8'h06: fl_wel = 1;
      8'h50: fl_vwel = 1;
      8'h01: if (fbytes.size() == 3 && (fl_wel || fl_vwel)) begin
        wr_lo = fbytes[1];
        wr_hi = fbytes[2];
        fl_reg = ((fl_reg & frozen) | ({wr_hi, wr_lo} & ~frozen)) & 16'hFFFC;
        if (fl_wel) busy_left = busy_cfg;
        fl_wel = 0;
        fl_vwel = 0;
        wr_end = cyc;
      end
      8'h05: if (busy_left > 0) busy_left--;
      default: ;
    endcase
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of the port rules
  always @(negedge clk) if (rst_n) begin
    chk(!(spi_cs_n && spi_sck), "R9", "sck high while deselected", spi_sck, 0);
    chk(!(done && busy), "R9", "busy at done", busy, 0);
  end

  task automatic run(input logic [15:0] m, input logic [15:0] v, input bit pers,
                     input bit le, input logic [1:0] lm, input int polls,
                     input logic [15:0] frz, input string tag);
    logic [15:0] cur, me, ve, nw, after;
    bit skip, tmo, elock;
    logic [7:0] exp[$];
    int np;
    cur = fl_reg;
    me = m | (le ? 16'h0180 : 16'h0000);
    ve = le ? ((v & ~16'h0180) | {7'b0, lm[1], lm[0], 7'b0}) : v;
    skip = (ve & me) == (cur & me);
    nw = (cur & ~me) | (ve & me);
    after = ((cur & frz) | (nw & ~frz)) & 16'hFFFC;
    tmo = !skip && pers && (polls >= PM);
    elock = !skip && !tmo && ((after & me) != (ve & me));
    exp.push_back(8'h05); exp.push_back(8'h35);
    if (!skip) begin
      exp.push_back(pers ? 8'h06 : 8'h50);
      exp.push_back(8'h01);
      if (pers) begin
        np = (polls >= PM) ? PM : polls + 1;
        for (int i = 0; i < np; i++) exp.push_back(8'h05);
      end
      if (!tmo) begin exp.push_back(8'h05); exp.push_back(8'h35); end
    end
    frozen = frz; busy_cfg = polls; ops.delete(); wr_end = -1; gap = -1;
    @(negedge clk);
    mask = m; value = v; persist = pers; lock_en = le; lock_mode = lm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", {tag, " busy after start"}, busy, 1);
    while (!done) @(negedge clk);
    chk(wrote == !skip, skip ? "R2" : "R4", {tag, " wrote"}, wrote, !skip);
    chk(err_timeout == tmo, "R5", {tag, " timeout flag"}, err_timeout, tmo);
    chk(err_lock == elock, "R7", {tag, " lock flag"}, err_lock, elock);
    chk(ops.size() == exp.size(), skip ? "R2" : "R1", {tag, " frame count"},
        ops.size(), exp.size());
    for (int i = 0; i < exp.size() && i < ops.size(); i++)
      chk(ops[i] == exp[i], (i < 2) ? "R1" : (i == 2) ? "R3" : "R5",
          {tag, " opcode"}, ops[i], exp[i]);
    if (!skip)
      chk({wr_hi, wr_lo} == nw, le ? "R8" : "R4", {tag, " written word"},
          {wr_hi, wr_lo}, nw);
    if (!skip && !pers)
      chk(gap >= US, "R6", {tag, " volatile gap"}, gap, US);
    @(negedge clk);
    chk(!busy && !done, "R10", {tag, " single done pulse"}, {busy, done}, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R10", "reset state", {spi_cs_n, spi_sck, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(16'h00F0, 16'h0030, 0, 0, 2'd0, 0, 16'h0000, "skip");
    run(16'h3C00, 16'h2800, 0, 0, 2'd0, 0, 16'h0000, "volatile");
    run(16'h00FC, 16'h00A8, 1, 0, 2'd0, 3, 16'h0000, "persist3");
    run(16'h0000, 16'h0000, 0, 1, 2'd2, 0, 16'h0000, "lock2");
    run(16'h8000, 16'h8000, 1, 1, 2'd1, 0, 16'h0000, "lock1");
    run(16'h0020, ~fl_reg & 16'h0020, 0, 0, 2'd0, 0, 16'h0020, "frozen");
    run(16'h0F00, ~fl_reg & 16'h0F00, 1, 0, 2'd0, PM - 1, 16'h0000, "lastpoll");
    run(16'h00C0, ~fl_reg & 16'h00C0, 1, 0, 2'd0, PM, 16'h0000, "timeout");
    busy_left = 0;
    run(16'h0000, 16'h0000, 1, 1, {fl_reg[8], fl_reg[7]}, 0, 16'h0000, "lockskip");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule